// File: doc/BRIEF.md
# Dual Endpoint Buffer Access Window

This block lets a small microcontroller reach two 8-byte endpoint data buffers through one byte-wide data register. A selector bit in a control register decides which buffer the data register maps to. Buffer 0 holds endpoint 0 data and buffer 1 holds endpoint 1 data. Both buffers share a single 3-bit circular index. Every read or write of the data register moves the index on by one, so firmware streams bytes in or out without addressing each one.

Firmware rewinds the index by writing a one to a write-only clear bit in the control register. Writes into buffer 0 are accepted only while an externally supplied receive-disable flag is low. A blocked write is dropped, but it still moves the index, so the firmware's byte count stays aligned with the index. The packet engine on the bus side and the neighbouring registers are outside this block.

Top module: `fifo_win`

## Requirements
- R1: After reset the selector is 0, the index is 0, and a control-register read returns 0x00.
- R2: A control-register read (offset 6) returns the selector in bit 0 and zero in bits 7..1. The clear bit (bit 1) always reads as 0, even after 0xFF is written.
- R3: With the selector at 0 the data register (offset 5) reaches buffer 0. With the selector at 1 it reaches buffer 1. The two buffers hold separate contents.
- R4: Each read or write of the data register advances the index by exactly one. A read returns the byte at the index as it was before the advance.
- R5: The index wraps from 7 to 0, so the ninth access after a clear reaches entry 0 again.
- R6: A control write with bit 1 set returns the index to 0 in the same cycle. A control write with bit 1 clear leaves the index unchanged.
- R7: While rx_disable is 1, a write to buffer 0 leaves its contents unchanged but still advances the index.
- R8: Writes to buffer 1 take effect whatever the value of rx_disable.
- R9: Changing the selector does not move the index. Both buffers are reached at the same index.
- R10: Accesses to any other offset (for example 7) change neither the index nor any buffer, and read as 0x00.
- R11: A cycle that asserts both read and write on the data register performs the write and advances the index only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| rx_disable | input | 1 | When high, writes into buffer 0 are refused |

## Verification
A wrong index does not show at once. It appears on the first data read after the fault, as a byte from the wrong entry. The bench therefore follows every sequence of pointer moves (clears, wraps, blocked writes, foreign offsets, selector changes) with readback of known patterns. A wrong selector or gating state shows on the next control read or buffer readback. That is at most a few bus cycles after the fault.

// File: rtl/fifo_win_pkg.sv
package fifo_win_pkg;
  localparam int unsigned SEL_BIT = 0;
  localparam int unsigned CLR_BIT = 1;
  localparam int unsigned DEF_DATA_OFS = 5;
  localparam int unsigned DEF_CTRL_OFS = 6;
  localparam int unsigned NUM_BUF = 2;
endpackage

// File: rtl/fifo_win_rst_sync.sv
module fifo_win_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fifo_win_decode.sv
module fifo_win_decode #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_OFS = 5,
  parameter int unsigned CTRL_OFS = 6,
  parameter int unsigned NUM_BUF  = 2
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wdata_sel,
  input  logic              wdata_clr,
  input  logic              sel_q,
  input  logic              rx_disable,
  output logic              data_rd,
  output logic              ctrl_rd,
  output logic              ptr_adv,
  output logic              ptr_clr,
  output logic              sel_en,
  output logic              sel_d,
  output logic [NUM_BUF-1:0] buf_we
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  logic data_hit;
  logic ctrl_hit;
  logic data_wr;

  always_comb begin
    data_hit = (bus_addr == DATA_A);
    ctrl_hit = (bus_addr == CTRL_A);
    data_rd  = data_hit & bus_rd;
    data_wr  = data_hit & bus_wr;
    ctrl_rd  = ctrl_hit & bus_rd;
    ptr_adv  = data_hit & (bus_rd | bus_wr);
    sel_en   = ctrl_hit & bus_wr;
    sel_d    = wdata_sel;
    ptr_clr  = sel_en & wdata_clr;
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_we
    if (b == 0) begin : g_gated
      assign buf_we[b] = data_wr & (sel_q == 1'b0) & ~rx_disable;
    end else begin : g_open
      assign buf_we[b] = data_wr & (sel_q == 1'b1);
    end
  end
endmodule

// File: rtl/fifo_win_ptr.sv
module fifo_win_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = adv | clr;
    if (clr) ptr_d = '0;
    else     ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/fifo_win_bank.sv
module fifo_win_bank #(
  parameter int unsigned NUM_BUF = 2,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic [NUM_BUF-1:0] we,
  input  logic [PTR_W-1:0]   idx,
  input  logic               sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] rd_buf [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[b]) mem[idx] <= wdata;
    end

    assign rd_buf[b] = mem[idx];
  end

  assign rdata = sel ? rd_buf[1] : rd_buf[0];
endmodule

// File: rtl/fifo_win.sv
module fifo_win
  import fifo_win_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned DATA_OFS = DEF_DATA_OFS,
  parameter int unsigned CTRL_OFS = DEF_CTRL_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_disable
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic               rst_n_sync;
  logic               data_rd;
  logic               ctrl_rd;
  logic               ptr_adv;
  logic               ptr_clr;
  logic               sel_en;
  logic               sel_d;
  logic               sel_q;
  logic [NUM_BUF-1:0] buf_we;
  logic [PTR_W-1:0]   ptr_q;
  logic [DATA_W-1:0]  bank_rdata;
  logic [DATA_W-1:0]  ctrl_rdata;

  fifo_win_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fifo_win_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_OFS (DATA_OFS),
    .CTRL_OFS (CTRL_OFS),
    .NUM_BUF  (NUM_BUF)
  ) u_dec (
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdata_sel  (bus_wdata[SEL_BIT]),
    .wdata_clr  (bus_wdata[CLR_BIT]),
    .sel_q      (sel_q),
    .rx_disable (rx_disable),
    .data_rd    (data_rd),
    .ctrl_rd    (ctrl_rd),
    .ptr_adv    (ptr_adv),
    .ptr_clr    (ptr_clr),
    .sel_en     (sel_en),
    .sel_d      (sel_d),
    .buf_we     (buf_we)
  );

  fifo_win_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .adv   (ptr_adv),
    .clr   (ptr_clr),
    .ptr_q (ptr_q)
  );

  fifo_win_bank #(
    .NUM_BUF (NUM_BUF),
    .DEPTH   (DEPTH),
    .DATA_W  (DATA_W)
  ) u_bank (
    .clk   (clk),
    .we    (buf_we),
    .idx   (ptr_q),
    .sel   (sel_q),
    .wdata (bus_wdata),
    .rdata (bank_rdata)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  sel_q <= 1'b0;
    else if (sel_en)  sel_q <= sel_d;
  end

  always_comb begin
    ctrl_rdata          = '0;
    ctrl_rdata[SEL_BIT] = sel_q;
    if (data_rd)      bus_rdata = bank_rdata;
    else if (ctrl_rd) bus_rdata = ctrl_rdata;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/fifo_win_chk.sv
module fifo_win_chk #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PTR_W    = 3,
  parameter int unsigned DATA_OFS = 5,
  parameter int unsigned CTRL_OFS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_disable,
  input logic              sel_q,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [1:0]        buf_we
);
  logic d_acc, c_wr, c_rd;
  assign d_acc = (bus_addr == ADDR_W'(DATA_OFS)) && (bus_rd || bus_wr);
  assign c_wr  = (bus_addr == ADDR_W'(CTRL_OFS)) && bus_wr;
  assign c_rd  = (bus_addr == ADDR_W'(CTRL_OFS)) && bus_rd;

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && bus_wdata[1]) |=> (ptr_q == '0)); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    d_acc |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R4

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_acc && !(c_wr && bus_wdata[1])) |=> $stable(ptr_q)); // R10

  AST_FF0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_disable && !sel_q) |-> !buf_we[0]); // R7

  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd |-> (bus_rdata[DATA_W-1:1] == '0 && bus_rdata[0] == sel_q)); // R2

  AST_ONE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_we)); // R3
endmodule

bind fifo_win fifo_win_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PTR_W    (PTR_W),
  .DATA_OFS (DATA_OFS),
  .CTRL_OFS (CTRL_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .rx_disable (rx_disable),
  .sel_q      (sel_q),
  .ptr_q      (ptr_q),
  .buf_we     (buf_we)
);

// File: tb/fifo_win_bench.sv
module fifo_win_bench;
  localparam int unsigned PERIOD = 10;
  localparam logic [2:0] AD = 3'd5;
  localparam logic [2:0] AC = 3'd6;
  localparam logic [2:0] AX = 3'd7;
  // {rd, wr, addr, wdata, rxdis, chk, exp}
  localparam int NV = 17;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b1,AC,8'h00,1'b0,1'b0,8'h00},
    {1'b0,1'b1,AD,8'h11,1'b0,1'b0,8'h00},
    {1'b0,1'b1,AD,8'h22,1'b0,1'b0,8'h00},
    {1'b0,1'b1,AC,8'h02,1'b0,1'b0,8'h00},
    {1'b1,1'b0,AD,8'h00,1'b0,1'b1,8'h11},
    {1'b1,1'b0,AD,8'h00,1'b0,1'b1,8'h22},
    {1'b0,1'b1,AC,8'h03,1'b0,1'b0,8'h00},
    {1'b0,1'b1,AD,8'hA0,1'b0,1'b0,8'h00},
    {1'b1,1'b0,AC,8'h00,1'b0,1'b1,8'h01},
    {1'b0,1'b1,AC,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b0,AD,8'h00,1'b0,1'b1,8'h22},
    {1'b0,1'b1,AC,8'h03,1'b0,1'b0,8'h00},
    {1'b1,1'b0,AD,8'h00,1'b0,1'b1,8'hA0},
    {1'b0,1'b1,AX,8'hFF,1'b0,1'b0,8'h00},
    {1'b1,1'b0,AX,8'h00,1'b0,1'b1,8'h00},
    {1'b0,1'b1,AC,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b0,AD,8'h00,1'b0,1'b1,8'h22}
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_rd;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       rx_disable;
  int checks;
  int errors;
  logic [7:0] got;

  fifo_win u_fifo_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_disable (rx_disable)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rd, input logic wr, input logic [2:0] a,
                     input logic [7:0] d, input logic rxd, output logic [7:0] rdat);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; rx_disable = rxd;
    #1 rdat = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; rx_disable = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    do_reset();
    // R1: control reads 0 after reset
    bus(1, 0, AC, 8'h00, 0, got); check("R1 ctrl after reset", got, 8'h00);

    // Table walk (R2 R3 R4 R6 R9 R10)
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][22], VEC[i][21], VEC[i][20:18], VEC[i][17:10], VEC[i][9], got);
      if (VEC[i][8]) check($sformatf("R3/R4/R6/R9/R10 vector %0d", i), got, VEC[i][7:0]);
    end

    // R2: clear bit reads as zero after 0xFF
    bus(0, 1, AC, 8'hFF, 0, got);
    bus(1, 0, AC, 8'h00, 0, got); check("R2 ctrl after FF", got, 8'h01);

    // R5: wrap, fill buffer 0
    bus(0, 1, AC, 8'h02, 0, got);
    for (int i = 0; i < 8; i++) bus(0, 1, AD, 8'(i*3+1), 0, got);
    bus(0, 1, AD, 8'h5A, 0, got);
    bus(0, 1, AC, 8'h02, 0, got);
    bus(1, 0, AD, 8'h00, 0, got); check("R5 wrapped write at 0", got, 8'h5A);
    for (int i = 1; i < 8; i++) begin
      bus(1, 0, AD, 8'h00, 0, got); check("R5 fill readback", got, 8'(i*3+1));
    end
    bus(1, 0, AD, 8'h00, 0, got); check("R5 read wraps to 0", got, 8'h5A);

    // R7: blocked FF0 writes still advance
    bus(0, 1, AC, 8'h02, 0, got);
    bus(0, 1, AD, 8'hEE, 1, got);
    bus(0, 1, AD, 8'hEE, 1, got);
    bus(1, 0, AD, 8'h00, 0, got); check("R7 index advanced by blocked writes", got, 8'd7);
    bus(0, 1, AC, 8'h02, 0, got);
    bus(1, 0, AD, 8'h00, 0, got); check("R7 entry 0 unchanged", got, 8'h5A);
    bus(1, 0, AD, 8'h00, 0, got); check("R7 entry 1 unchanged", got, 8'd4);

    // R8: FF1 writes ignore rx_disable
    bus(0, 1, AC, 8'h03, 1, got);
    bus(0, 1, AD, 8'hC3, 1, got);
    bus(0, 1, AC, 8'h03, 1, got);
    bus(1, 0, AD, 8'h00, 1, got); check("R8 FF1 write under rx_disable", got, 8'hC3);

    // R11: simultaneous read and write advance once
    bus(0, 1, AC, 8'h03, 0, got);
    bus(1, 1, AD, 8'h77, 0, got);
    bus(0, 1, AD, 8'h88, 0, got);
    bus(0, 1, AC, 8'h03, 0, got);
    bus(1, 0, AD, 8'h00, 0, got); check("R11 entry 0", got, 8'h77);
    bus(1, 0, AD, 8'h00, 0, got); check("R11 entry 1", got, 8'h88);

    // R1: reset mid-run restores selector and index
    do_reset();
    bus(1, 0, AC, 8'h00, 0, got); check("R1 ctrl after second reset", got, 8'h00);
    bus(1, 0, AD, 8'h00, 0, got); check("R1 index 0 selector 0", got, 8'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule